// File: doc/BRIEF.md
# Strobe-Clocked Byte Link Slave

This block is the programmable-logic end of a slow, full-duplex byte link to a host microcontroller. The host sends and receives one byte at a time over two separate 8-bit ports. It marks each transfer by toggling a strobe line from software, so the strobe is not a real clock. The block runs entirely on its own fast system clock. It passes the strobe and the host reset through synchronisers and acts once on each detected rising strobe edge.

Bytes from the host go into a receive FIFO. Bytes that user logic wants to send wait in a transmit FIFO. User logic sees each direction as a plain valid/ready byte stream and can also read the full and empty flags of both FIFOs. Flow control on the link uses separate lines in each direction. The block raises a ready line toward the host while it can take another byte, and raises a valid line while a byte is on its output port. A single strobe edge can move one byte in each direction at once.

Top module: `byte_link_slave`

## Requirements
- R1: After system reset both FIFOs are empty: `rx_empty`=1, `tx_empty`=1, `rx_full`=0, `tx_full`=0, `link_rx_ready`=1, `link_tx_valid`=0, `usr_rx_valid`=0.
- R2: Each low-to-high transition of `host_strobe` causes exactly one link action, however long the strobe stays high. Falling edges and steady levels cause none.
- R3: On a strobe rising edge with `host_rx_valid`=1 and `link_rx_ready`=1, the byte on `host_rx_data` is stored. User logic receives the stored bytes on `usr_rx_data`/`usr_rx_valid` in arrival order, one byte per cycle with `usr_rx_ready`=1.
- R4: A strobe rising edge with `host_rx_valid`=0 stores nothing.
- R5: With 16 bytes held in the receive FIFO (default depth), `link_rx_ready` is 0 and `rx_full` is 1. A further strobe edge stores nothing, and the held bytes stay intact.
- R6: `link_tx_valid` is 1 exactly while the transmit FIFO is non-empty. `link_tx_data` shows the oldest unsent byte and holds it until a strobe edge consumes it.
- R7: A strobe rising edge while `link_tx_valid`=1 consumes the byte. The next byte is then presented, or `link_tx_valid` falls if none is left.
- R8: `usr_tx_ready` = !`tx_full`. A cycle with `usr_tx_valid`=1 and `usr_tx_ready`=1 appends `usr_tx_data`, and up to 16 bytes are held.
- R9: A single strobe edge can both store an incoming byte and consume an outgoing one.
- R10: Holding `host_reset` high for at least three system clocks empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| host_strobe | input | 1 | Software-toggled transfer strobe from the host (asynchronous) |
| host_reset | input | 1 | Interface reset from the host, active high (asynchronous) |
| host_rx_data | input | 8 | Byte driven by the host toward the block |
| host_rx_valid | input | 1 | Host has a byte on `host_rx_data` |
| link_rx_ready | output | 1 | Block can accept another byte from the host |
| link_tx_data | output | 8 | Byte driven by the block toward the host |
| link_tx_valid | output | 1 | Block has a byte on `link_tx_data` |
| usr_rx_data | output | 8 | Oldest received byte |
| usr_rx_valid | output | 1 | A received byte is available |
| usr_rx_ready | input | 1 | User logic takes the received byte |
| usr_tx_data | input | 8 | Byte from user logic to send |
| usr_tx_valid | input | 1 | User logic offers a byte to send |
| usr_tx_ready | output | 1 | Transmit FIFO has room |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |

## Verification
The bench holds the strobe high for many clocks to catch level-triggered actions: a design that did not detect edges would store or send a byte every cycle. It fills the receive FIFO and strobes once more with valid high. A design missing the full guard would overwrite the oldest byte or wrap its count, and the drained sequence would come out wrong. It strobes with the host's valid low, runs full-duplex strobes against a one-entry transmit FIFO so that valid must fall on the same edge that stores a byte, and pulses the host reset with both FIFOs loaded. Random mixes of strobes and user pushes and pops are compared with a queue model after every operation.

// File: rtl/blink_pkg.sv
package blink_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/blink_sync.sv
module blink_sync #(
   parameter int unsigned STAGES = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("blink_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/blink_edge.sv
module blink_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic level,
   output logic pulse
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prev <= ~RISING;
      else if (clr) prev <= level;
      else          prev <= level;
   end

   if (RISING) begin : g_rise
      assign pulse = level & ~prev & ~clr;
   end else begin : g_fall
      assign pulse = ~level & prev & ~clr;
   end

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/blink_fifo.sv
module blink_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("blink_fifo: DEPTH must be a power of two, at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("blink_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;

   assign full    = (count == DEPTH_C);
   assign empty   = (count == '0);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
   a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !rd_en && !clr) |=> (!empty && $stable(rd_data)));
endmodule

// File: rtl/byte_link_slave.sv
module byte_link_slave #(
   parameter int unsigned RX_DEPTH    = 16,
   parameter int unsigned TX_DEPTH    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_strobe,
   input  logic       host_reset,
   input  logic [7:0] host_rx_data,
   input  logic       host_rx_valid,
   output logic       link_rx_ready,
   output logic [7:0] link_tx_data,
   output logic       link_tx_valid,
   output logic [7:0] usr_rx_data,
   output logic       usr_rx_valid,
   input  logic       usr_rx_ready,
   input  logic [7:0] usr_tx_data,
   input  logic       usr_tx_valid,
   output logic       usr_tx_ready,
   output logic       rx_full,
   output logic       rx_empty,
   output logic       tx_full,
   output logic       tx_empty
);
   import blink_pkg::*;

   logic  strobe_lvl, host_clr, strobe_edge;
   logic  rx_wr, rx_rd, tx_wr, tx_rd;
   byte_t rx_head, tx_head;

   blink_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_strobe (
      .clk(clk), .rst_n(rst_n), .async_in(host_strobe), .sync_out(strobe_lvl));

   blink_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_reset (
      .clk(clk), .rst_n(rst_n), .async_in(host_reset), .sync_out(host_clr));

   blink_edge #(.RISING(1'b1)) u_edge (
      .clk(clk), .rst_n(rst_n), .clr(host_clr),
      .level(strobe_lvl), .pulse(strobe_edge));

   assign rx_wr = strobe_edge & host_rx_valid & ~rx_full;
   assign rx_rd = usr_rx_valid & usr_rx_ready & ~host_clr;
   assign tx_wr = usr_tx_valid & ~tx_full & ~host_clr;
   assign tx_rd = strobe_edge & ~tx_empty;

   blink_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(host_clr),
      .wr_en(rx_wr), .wr_data(host_rx_data),
      .rd_en(rx_rd), .rd_data(rx_head),
      .full(rx_full), .empty(rx_empty));

   blink_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(host_clr),
      .wr_en(tx_wr), .wr_data(usr_tx_data),
      .rd_en(tx_rd), .rd_data(tx_head),
      .full(tx_full), .empty(tx_empty));

   assign link_rx_ready = ~rx_full;
   assign link_tx_valid = ~tx_empty;
   assign link_tx_data  = tx_head;
   assign usr_rx_valid  = ~rx_empty;
   assign usr_rx_data   = rx_head;
   assign usr_tx_ready  = ~tx_full;

   a_r10_host_clear: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> (rx_empty && tx_empty));
   a_r4_no_store_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_rx_valid && !usr_rx_ready && rx_empty && !host_clr) |=> rx_empty);
   a_r7_tx_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_edge && !host_clr && link_tx_valid) |=> link_tx_valid);
endmodule

// File: tb/byte_link_slave_test.sv
module byte_link_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_strobe = 1'b0, host_reset = 1'b0;
   logic [7:0] host_rx_data = '0;
   logic       host_rx_valid = 1'b0;
   logic       link_rx_ready, link_tx_valid;
   logic [7:0] link_tx_data, usr_rx_data;
   logic       usr_rx_valid;
   logic       usr_rx_ready = 1'b0;
   logic [7:0] usr_tx_data = '0;
   logic       usr_tx_valid = 1'b0;
   logic       usr_tx_ready, rx_full, rx_empty, tx_full, tx_empty;

   int checks = 0, failures = 0;
   logic [7:0] rxq[$];
   logic [7:0] txq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_link_slave uut (
      .clk(clk), .rst_n(rst_n), .host_strobe(host_strobe), .host_reset(host_reset),
      .host_rx_data(host_rx_data), .host_rx_valid(host_rx_valid),
      .link_rx_ready(link_rx_ready), .link_tx_data(link_tx_data),
      .link_tx_valid(link_tx_valid), .usr_rx_data(usr_rx_data),
      .usr_rx_valid(usr_rx_valid), .usr_rx_ready(usr_rx_ready),
      .usr_tx_data(usr_tx_data), .usr_tx_valid(usr_tx_valid),
      .usr_tx_ready(usr_tx_ready), .rx_full(rx_full), .rx_empty(rx_empty),
      .tx_full(tx_full), .tx_empty(tx_empty));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_ready(input int n);
      return n < DEPTH;
   endfunction

   // compare all visible state with the queue model (called at a negedge)
   task automatic check_model(input string tag);
      chk(rx_empty == (rxq.size() == 0), {tag, " R3 rx_empty"}, rx_empty, rxq.size() == 0);
      chk(rx_full == (rxq.size() == DEPTH), {tag, " R5 rx_full"}, rx_full, rxq.size() == DEPTH);
      chk(link_rx_ready == exp_ready(rxq.size()), {tag, " R5 link_rx_ready"},
          link_rx_ready, exp_ready(rxq.size()));
      chk(tx_full == (txq.size() == DEPTH), {tag, " R8 tx_full"}, tx_full, txq.size() == DEPTH);
      chk(usr_tx_ready == exp_ready(txq.size()), {tag, " R8 usr_tx_ready"},
          usr_tx_ready, exp_ready(txq.size()));
      chk(link_tx_valid == (txq.size() != 0), {tag, " R6 link_tx_valid"},
          link_tx_valid, txq.size() != 0);
      if (txq.size() != 0)
         chk(link_tx_data == txq[0], {tag, " R6 link_tx_data"}, link_tx_data, txq[0]);
      if (rxq.size() != 0)
         chk(usr_rx_data == rxq[0], {tag, " R3 usr_rx_data"}, usr_rx_data, rxq[0]);
   endtask

   // one strobe transfer; high_clks >= 4 lets the synchroniser and edge act
   task automatic host_xfer(input bit vld, input logic [7:0] d, input int high_clks);
      @(negedge clk);
      host_rx_data  = d;
      host_rx_valid = vld;
      @(negedge clk);
      host_strobe = 1'b1;
      repeat (high_clks) @(negedge clk);
      host_strobe = 1'b0;
      repeat (4) @(negedge clk);
      host_rx_valid = 1'b0;
      if (vld && rxq.size() < DEPTH) rxq.push_back(d);
      if (txq.size() != 0) void'(txq.pop_front());
   endtask

   task automatic user_push(input logic [7:0] d);
      @(negedge clk);
      usr_tx_data  = d;
      usr_tx_valid = 1'b1;
      if (usr_tx_ready) txq.push_back(d);
      @(negedge clk);
      usr_tx_valid = 1'b0;
   endtask

   task automatic user_pop(input string tag);
      @(negedge clk);
      if (rxq.size() != 0) begin
         chk(usr_rx_valid == 1'b1, {tag, " R3 usr_rx_valid"}, usr_rx_valid, 1);
         chk(usr_rx_data == rxq[0], {tag, " R3 order"}, usr_rx_data, rxq[0]);
         void'(rxq.pop_front());
      end else begin
         chk(usr_rx_valid == 1'b0, {tag, " R3 no data"}, usr_rx_valid, 0);
      end
      usr_rx_ready = 1'b1;
      @(negedge clk);
      usr_rx_ready = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk(rx_empty && tx_empty && !rx_full && !tx_full, "R1 flags", {rx_empty, tx_empty, rx_full, tx_full}, 4'b1100);
      chk(link_rx_ready && !link_tx_valid && !usr_rx_valid, "R1 link",
          {link_rx_ready, link_tx_valid, usr_rx_valid}, 3'b100);

      // R4 strobe without valid stores nothing
      host_xfer(1'b0, 8'hA5, 4);
      chk(rx_empty == 1'b1, "R4 no store", rx_empty, 1);

      // R2 long strobe high: exactly one byte
      host_xfer(1'b1, 8'h3C, 40);
      check_model("R2 long-high");
      user_pop("R2 drain");
      chk(rx_empty == 1'b1, "R2 single action", rx_empty, 1);

      // R5 fill to 16, then one more with valid
      for (int i = 0; i < DEPTH; i++) host_xfer(1'b1, 8'(8'h10 + i), 4);
      chk(rx_full && !link_rx_ready, "R5 full at 16", {rx_full, link_rx_ready}, 2'b10);
      host_xfer(1'b1, 8'hEE, 4);
      check_model("R5 extra");
      for (int i = 0; i < DEPTH; i++) user_pop("R5 drain");
      chk(rx_empty == 1'b1, "R5 drained", rx_empty, 1);

      // R8 fill transmit FIFO
      for (int i = 0; i < DEPTH + 1; i++) user_push(8'(8'h80 + i));
      chk(tx_full && !usr_tx_ready, "R8 full at 16", {tx_full, usr_tx_ready}, 2'b10);
      check_model("R8 fill");
      // R7 consume in order
      for (int i = 0; i < DEPTH; i++) begin
         host_xfer(1'b0, 8'h00, 4);
         check_model("R7 consume");
      end
      chk(!link_tx_valid, "R7 valid falls", link_tx_valid, 0);

      // R9 full duplex on one edge
      user_push(8'h5A);
      host_xfer(1'b1, 8'hC3, 4);
      check_model("R9 duplex");
      chk(!link_tx_valid && usr_rx_valid, "R9 both moved", {link_tx_valid, usr_rx_valid}, 2'b01);

      // R10 host reset clears both FIFOs
      user_push(8'h11);
      user_push(8'h22);
      host_xfer(1'b1, 8'h33, 4);
      @(negedge clk);
      host_reset = 1'b1;
      repeat (4) @(negedge clk);
      host_reset = 1'b0;
      repeat (3) @(negedge clk);
      rxq.delete();
      txq.delete();
      chk(rx_empty && tx_empty && !link_tx_valid, "R10 cleared",
          {rx_empty, tx_empty, link_tx_valid}, 3'b110);
      check_model("R10 after");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom_range(0, 2);
         case (op)
            0: host_xfer(1'($urandom_range(0, 3) != 0), 8'($urandom()), $urandom_range(3, 8));
            1: user_push(8'($urandom()));
            default: user_pop("R3 random");
         endcase
         check_model("random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule